// File: doc/BRIEF.md
# Wrapping Hardware Stack Pointer Unit

This block keeps the stack pointer of a small 8-bit processor core. The stack is a fixed window of 128 bytes in data memory at 0100h..017Fh. Only the low seven bits of the pointer change. The upper nine bits are tied by hardware, so the pointer wraps inside the window without any warning, and the oldest data is simply overwritten. The pointer always holds the next free location. A push writes at the pointer and then moves it down. A pop first moves the pointer up and then reads there.

The unit drives the memory address, a write strobe, a read strobe and a byte-select code, one byte per clock. The core uses the select code to steer the write data or the read result to the right register. Single-byte push and pop are supported. So are multi-byte sequences:
- a call saves two program-counter bytes;
- interrupt entry saves five bytes (program counter, X, A, condition codes);
- return and return-from-interrupt restore those bytes in exact reverse order.

Two commands change the pointer with no memory access. The reset-stack command sets it back to 017Fh. A direct load writes the low byte of the pointer.

The controller is a finite state machine with these states:
- `ST_IDLE` accepts commands.
- `ST_PUSH` and `ST_POP` handle single bytes.
- `ST_CALL_PCL` then `ST_CALL_PCH` save the call return address.
- `ST_INT_PCL`, `ST_INT_PCH`, `ST_INT_X`, `ST_INT_A`, `ST_INT_CC` save the interrupt context.
- `ST_RET_PCH` then `ST_RET_PCL` handle return.
- `ST_IRET_CC`, `ST_IRET_A`, `ST_IRET_X`, `ST_IRET_PCH`, `ST_IRET_PCL` handle return-from-interrupt.

Every state except `ST_IDLE` lasts exactly one clock. Each sequence state steps to the next state in the order listed, and the last state of each sequence returns to `ST_IDLE`. `ST_IDLE` moves to the first state of whichever accepted command has the highest priority. When no command is present, or when the command is reset-stack or load, `ST_IDLE` stays in `ST_IDLE`.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, `sp_o` is 017Fh, `busy_o` is 0, and neither strobe is active.
- R2: A push command gives, in the following cycle, one write (`mem_we_o`=1) at address `sp_o` with `byte_sel_o`=6 (data byte). The pointer then decreases by one. The select codes are: 1=PC low, 2=PC high, 3=X, 4=A, 5=CC, 6=data byte, 0=none.
- R3: A pop command gives, in the following cycle, one read (`mem_re_o`=1) with `byte_sel_o`=6 at address `sp_o`+1. The pointer then equals that address.
- R4: The pointer and every strobed address always stay within 0100h..017Fh. A decrement from 0100h gives 017Fh, and an increment from 017Fh gives 0100h.
- R5: A call writes PC low at the current pointer, then PC high one below it, in two consecutive cycles. The pointer ends 2 lower.
- R6: Interrupt entry writes PC low, PC high, X, A, CC in five consecutive cycles at descending addresses. The pointer ends 5 lower. No select code for the Y register exists.
- R7: A return reads PC high, then PC low, in two consecutive cycles at ascending addresses. The pointer ends 2 higher.
- R8: Return-from-interrupt reads CC, A, X, PC high, PC low in five consecutive cycles at ascending addresses. The pointer ends 5 higher.
- R9: The reset-stack command sets `sp_o` to 017Fh in the next cycle, with no strobe.
- R10: The load command sets the low seven bits of the pointer from `sp_load_data_i[6:0]` in the next cycle, with no strobe. Bit 7 of the load data is ignored.
- R11: `busy_o` is 1 exactly in the strobe cycles of a sequence. Every command presented while `busy_o` is 1 is ignored, and no strobe occurs while `busy_o` is 0.
- R12: When several commands arrive together in idle, only one is taken, in this priority order: reset-stack, load, interrupt, call, return-from-interrupt, return, push, pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push one data byte |
| pop_i | input | 1 | Pop one data byte |
| call_i | input | 1 | Save the two program-counter bytes |
| irq_i | input | 1 | Save the five-byte interrupt context |
| ret_i | input | 1 | Restore the two program-counter bytes |
| iret_i | input | 1 | Restore the five-byte interrupt context |
| sp_reset_i | input | 1 | Set the pointer to the top of the window |
| sp_load_i | input | 1 | Load the low byte of the pointer |
| sp_load_data_i | input | 8 | Value for the load; only bits 6:0 are used |
| sp_o | output | 16 | Current stack pointer |
| mem_addr_o | output | 16 | Memory address for the current strobe |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| byte_sel_o | output | 3 | Register written or read this cycle |
| busy_o | output | 1 | A command is being executed |

## Verification
A corrupted pointer shows on `mem_addr_o` at the very next strobe. It also shows on `sp_o` one cycle after any command, because the bench's model predicts every address. A state machine that skips, repeats or reorders a state shows within the sequence itself: the `byte_sel_o` code is wrong in that cycle, or the strobe count is wrong, or `busy_o` stays high too long.

A fault in the wrap logic only appears when the pointer crosses 0100h or 017Fh. Directed crossings in both directions are therefore placed just after reset. A fault in the ignore-while-busy rule appears as an extra pointer step, visible on `sp_o` as soon as the sequence ends.

// File: rtl/stkp_pkg.sv
package stkp_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_CALL_PCL,
        ST_CALL_PCH,
        ST_INT_PCL,
        ST_INT_PCH,
        ST_INT_X,
        ST_INT_A,
        ST_INT_CC,
        ST_RET_PCH,
        ST_RET_PCL,
        ST_IRET_CC,
        ST_IRET_A,
        ST_IRET_X,
        ST_IRET_PCH,
        ST_IRET_PCL
    } stk_state_e;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_PCL  = 3'd1,
        SEL_PCH  = 3'd2,
        SEL_X    = 3'd3,
        SEL_A    = 3'd4,
        SEL_CC   = 3'd5,
        SEL_DATA = 3'd6
    } byte_sel_e;

endpackage

// File: rtl/stkp_ptr.sv
module stkp_ptr #(
    parameter int          ADDR_W   = 16,
    parameter int          WIN_BITS = 7,
    parameter logic [15:0] WIN_BASE = 16'h0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_top,
    input  logic                load_en,
    input  logic [WIN_BITS-1:0] load_val,
    input  logic                step_dn,
    input  logic                step_up,
    output logic [ADDR_W-1:0]   sp_addr,
    output logic [ADDR_W-1:0]   sp_up_addr
);
    localparam int HI_W = ADDR_W - WIN_BITS;
    localparam logic [HI_W-1:0] HI_FIXED = WIN_BASE[ADDR_W-1:WIN_BITS];

    logic [WIN_BITS-1:0] sp_lo;
    logic [WIN_BITS-1:0] sp_lo_up;

    assign sp_lo_up   = sp_lo + 1'b1;
    assign sp_addr    = {HI_FIXED, sp_lo};
    assign sp_up_addr = {HI_FIXED, sp_lo_up};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_lo <= '1;
        end else if (set_top) begin
            sp_lo <= '1;
        end else if (load_en) begin
            sp_lo <= load_val;
        end else if (step_dn) begin
            sp_lo <= sp_lo - 1'b1;
        end else if (step_up) begin
            sp_lo <= sp_lo_up;
        end
    end

    assert_wrap_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !set_top && !load_en && sp_lo == '0) |=> (sp_lo == '1));

    assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !step_dn && !set_top && !load_en && sp_lo == '1) |=> (sp_lo == '0));

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !set_top) |=> (sp_lo == $past(load_val)));

endmodule

// File: rtl/stkp_seq.sv
module stkp_seq
    import stkp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  logic      pop_i,
    input  logic      call_i,
    input  logic      irq_i,
    input  logic      ret_i,
    input  logic      iret_i,
    input  logic      sp_reset_i,
    input  logic      sp_load_i,
    output logic      we,
    output logic      re,
    output byte_sel_e sel,
    output logic      step_dn,
    output logic      step_up,
    output logic      set_top,
    output logic      load_en,
    output logic      busy
);
    stk_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (sp_reset_i || sp_load_i) state_nx = ST_IDLE;
                else if (irq_i)              state_nx = ST_INT_PCL;
                else if (call_i)             state_nx = ST_CALL_PCL;
                else if (iret_i)             state_nx = ST_IRET_CC;
                else if (ret_i)              state_nx = ST_RET_PCH;
                else if (push_i)             state_nx = ST_PUSH;
                else if (pop_i)              state_nx = ST_POP;
                else                         state_nx = ST_IDLE;
            end
            ST_CALL_PCL: state_nx = ST_CALL_PCH;
            ST_INT_PCL:  state_nx = ST_INT_PCH;
            ST_INT_PCH:  state_nx = ST_INT_X;
            ST_INT_X:    state_nx = ST_INT_A;
            ST_INT_A:    state_nx = ST_INT_CC;
            ST_RET_PCH:  state_nx = ST_RET_PCL;
            ST_IRET_CC:  state_nx = ST_IRET_A;
            ST_IRET_A:   state_nx = ST_IRET_X;
            ST_IRET_X:   state_nx = ST_IRET_PCH;
            ST_IRET_PCH: state_nx = ST_IRET_PCL;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        we      = 1'b0;
        re      = 1'b0;
        sel     = SEL_NONE;
        set_top = 1'b0;
        load_en = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                set_top = sp_reset_i;
                load_en = sp_load_i && !sp_reset_i;
            end
            ST_PUSH:     begin we = 1'b1; sel = SEL_DATA; end
            ST_CALL_PCL: begin we = 1'b1; sel = SEL_PCL;  end
            ST_CALL_PCH: begin we = 1'b1; sel = SEL_PCH;  end
            ST_INT_PCL:  begin we = 1'b1; sel = SEL_PCL;  end
            ST_INT_PCH:  begin we = 1'b1; sel = SEL_PCH;  end
            ST_INT_X:    begin we = 1'b1; sel = SEL_X;    end
            ST_INT_A:    begin we = 1'b1; sel = SEL_A;    end
            ST_INT_CC:   begin we = 1'b1; sel = SEL_CC;   end
            ST_POP:      begin re = 1'b1; sel = SEL_DATA; end
            ST_RET_PCH:  begin re = 1'b1; sel = SEL_PCH;  end
            ST_RET_PCL:  begin re = 1'b1; sel = SEL_PCL;  end
            ST_IRET_CC:  begin re = 1'b1; sel = SEL_CC;   end
            ST_IRET_A:   begin re = 1'b1; sel = SEL_A;    end
            ST_IRET_X:   begin re = 1'b1; sel = SEL_X;    end
            ST_IRET_PCH: begin re = 1'b1; sel = SEL_PCH;  end
            ST_IRET_PCL: begin re = 1'b1; sel = SEL_PCL;  end
            default:     busy = 1'b0;
        endcase
    end

    assign step_dn = we;
    assign step_up = re;

    assert_busy_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we || re) |-> busy);

    assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!set_top && !load_en));

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stkp_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          WIN_BITS = 7,
    parameter logic [15:0] WIN_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              call_i,
    input  logic              irq_i,
    input  logic              ret_i,
    input  logic              iret_i,
    input  logic              sp_reset_i,
    input  logic              sp_load_i,
    input  logic [7:0]        sp_load_data_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [2:0]        byte_sel_o,
    output logic              busy_o
);
    localparam int HI_W = ADDR_W - WIN_BITS;
    localparam logic [HI_W-1:0] HI_FIXED = WIN_BASE[ADDR_W-1:WIN_BITS];

    logic      we, re, step_dn, step_up, set_top, load_en;
    byte_sel_e sel;
    logic [ADDR_W-1:0] sp_addr, sp_up_addr;

    stkp_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_i),
        .pop_i      (pop_i),
        .call_i     (call_i),
        .irq_i      (irq_i),
        .ret_i      (ret_i),
        .iret_i     (iret_i),
        .sp_reset_i (sp_reset_i),
        .sp_load_i  (sp_load_i),
        .we         (we),
        .re         (re),
        .sel        (sel),
        .step_dn    (step_dn),
        .step_up    (step_up),
        .set_top    (set_top),
        .load_en    (load_en),
        .busy       (busy_o)
    );

    stkp_ptr #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .WIN_BASE (WIN_BASE)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_top    (set_top),
        .load_en    (load_en),
        .load_val   (sp_load_data_i[WIN_BITS-1:0]),
        .step_dn    (step_dn),
        .step_up    (step_up),
        .sp_addr    (sp_addr),
        .sp_up_addr (sp_up_addr)
    );

    assign sp_o       = sp_addr;
    assign mem_addr_o = re ? sp_up_addr : sp_addr;
    assign mem_we_o   = we;
    assign mem_re_o   = re;
    assign byte_sel_o = sel;

    assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |-> (mem_addr_o[ADDR_W-1:WIN_BITS] == HI_FIXED));

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (sp_o[WIN_BITS-1:0] == $past(mem_addr_o[WIN_BITS-1:0]) - 1'b1));

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> (sp_o == $past(mem_addr_o)));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    assert_int_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && byte_sel_o == SEL_X) |-> $past(mem_we_o && byte_sel_o == SEL_PCH));

    assert_iret_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_o && byte_sel_o == SEL_A) |-> $past(mem_re_o && byte_sel_o == SEL_CC));

endmodule

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, pop_i = 0, call_i = 0, irq_i = 0;
    logic        ret_i = 0, iret_i = 0, sp_reset_i = 0, sp_load_i = 0;
    logic [7:0]  sp_load_data_i = 8'h00;
    logic [15:0] sp_o, mem_addr_o;
    logic        mem_we_o, mem_re_o, busy_o;
    logic [2:0]  byte_sel_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] m_lo;

    always #2 clk = ~clk;

    stack_ptr_unit i_stack_ptr_unit (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .pop_i(pop_i), .call_i(call_i), .irq_i(irq_i),
        .ret_i(ret_i), .iret_i(iret_i), .sp_reset_i(sp_reset_i),
        .sp_load_i(sp_load_i), .sp_load_data_i(sp_load_data_i),
        .sp_o(sp_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
        .mem_re_o(mem_re_o), .byte_sel_o(byte_sel_o), .busy_o(busy_o)
    );

    // command kinds: 0 push,1 pop,2 call,3 irq,4 ret,5 iret,6 reset-stack,7 load
    function automatic int pick(input logic [7:0] m);
        if (m[6]) return 6;
        if (m[7]) return 7;
        if (m[3]) return 3;
        if (m[2]) return 2;
        if (m[5]) return 5;
        if (m[4]) return 4;
        if (m[0]) return 0;
        if (m[1]) return 1;
        return -1;
    endfunction

    function automatic int seq_len(input int k);
        case (k)
            0, 1: return 1;
            2, 4: return 2;
            3, 5: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [2:0] exp_sel(input int k, input int i);
        case (k)
            0, 1: return 3'd6;
            2: return (i == 0) ? 3'd1 : 3'd2;
            3: return 3'(i + 1);
            4: return (i == 0) ? 3'd2 : 3'd1;
            5: return 3'(5 - i);
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [15:0] m_sp();
        return {9'b0000_0001_0, m_lo};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] m, input logic [7:0] ld);
        push_i = m[0]; pop_i = m[1]; call_i = m[2]; irq_i = m[3];
        ret_i = m[4]; iret_i = m[5]; sp_reset_i = m[6]; sp_load_i = m[7];
        sp_load_data_i = ld;
    endtask

    // called right after a negedge; returns right after a negedge with the unit idle
    task automatic do_cmd(input logic [7:0] m, input logic [7:0] ld, input bit junk);
        int k;
        int n;
        bit wr;
        k = pick(m);
        drive(m, ld);
        @(negedge clk);
        drive(8'h00, 8'h00);
        if (k == 6) begin
            m_lo = 7'h7F;
            check("R9 sp after reset-stack", sp_o, m_sp());
            check("R9 no strobe", {mem_we_o, mem_re_o}, 0);
            return;
        end
        if (k == 7) begin
            m_lo = ld[6:0];
            check("R10 sp after load", sp_o, m_sp());
            check("R10 no strobe", {mem_we_o, mem_re_o}, 0);
            return;
        end
        if (k < 0) begin
            check("R11 idle quiet", {busy_o, mem_we_o, mem_re_o}, 0);
            return;
        end
        n  = seq_len(k);
        wr = (k == 0 || k == 2 || k == 3);
        for (int i = 0; i < n; i++) begin
            if (wr) begin
                check("R2/R5/R6 write strobe", {mem_we_o, mem_re_o}, 2'b10);
                check("R2/R5/R6 write addr", mem_addr_o, m_sp());
                m_lo = m_lo - 7'd1;
            end else begin
                m_lo = m_lo + 7'd1;
                check("R3/R7/R8 read strobe", {mem_we_o, mem_re_o}, 2'b01);
                check("R3/R7/R8 read addr", mem_addr_o, m_sp());
            end
            check("R5/R6/R7/R8 byte select", byte_sel_o, exp_sel(k, i));
            check("R11 busy in sequence", busy_o, 1);
            if (junk && i < n - 1) drive(8'($urandom_range(1, 255)), 8'($urandom));
            else drive(8'h00, 8'h00);
            @(negedge clk);
        end
        drive(8'h00, 8'h00);
        check("R11 busy released", busy_o, 0);
        check("R4 sp after sequence", sp_o, m_sp());
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_lo = 7'h7F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset sp", sp_o, 16'h017F);
        check("R1 reset busy/strobes", {busy_o, mem_we_o, mem_re_o}, 0);

        // R4 wrap upward: pop from 017F reads 0100
        do_cmd(8'h02, 8'h00, 0);
        check("R4 wrap up", sp_o, 16'h0100);
        // R4 wrap downward: push at 0100 lands on 017F
        do_cmd(8'h01, 8'h00, 0);
        check("R4 wrap down", sp_o, 16'h017F);
        // R6 then R8 across the wrap boundary
        do_cmd(8'h80, 8'h02, 0);
        do_cmd(8'h08, 8'h00, 0);
        do_cmd(8'h20, 8'h00, 0);
        // R5, R7
        do_cmd(8'h04, 8'h00, 0);
        do_cmd(8'h10, 8'h00, 0);
        // R10: bit 7 of load data ignored
        do_cmd(8'h80, 8'hC5, 0);
        check("R10 bit7 ignored", sp_o, 16'h0145);
        // R11: commands during interrupt entry ignored
        do_cmd(8'h08, 8'h00, 1);
        do_cmd(8'h20, 8'h00, 1);
        // R12 priority cases
        do_cmd(8'hFF, 8'h11, 0);
        check("R12 reset-stack wins", sp_o, 16'h017F);
        do_cmd(8'hBF, 8'h33, 0);
        check("R12 load wins", sp_o, 16'h0133);
        do_cmd(8'h3F, 8'h00, 0);
        do_cmd(8'h37, 8'h00, 0);
        do_cmd(8'h33, 8'h00, 0);
        do_cmd(8'h13, 8'h00, 0);
        do_cmd(8'h03, 8'h00, 0);

        for (int r = 0; r < 400; r++) begin
            logic [7:0] m;
            m = 8'(1 << $urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) m = m | 8'($urandom) & 8'h3F;
            do_cmd(m, 8'($urandom), $urandom_range(0, 1) == 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule